// File: doc/BRIEF.md
# Periodic Duty-Cycle Throttle Generator

This block produces a ready level that is held back for a set share of every repeating period. A test environment uses it to act as a slow link partner. One channel drives an active-low hardware handshake line, where a high level tells the sender to stop. A second channel drives a software flow-control "receive allowed" flag. Both channels use the same timing rule, and each has its own period and fraction settings. Those settings may change at any time while the block runs.

Each channel holds a down-counter that runs from period-1 to zero and then starts again. If the count is out of range, it is reloaded to period-1. The ready level is registered. It is withheld on every clock edge where the new count is below the fraction setting. A period of zero turns throttling off for that channel. Serial framing, and the logic that reads the ready level, are not part of this block.

Top module: `throttle_gen`

## Requirements
- R1: While reset is low and on the first cycle after it is released, both channels report ready: `flag_ready` is 1 and `line_hold_n` is 0. Reset also clears each count to zero.
- R2: While a channel's period is 0, its ready level stays asserted on every clock, whatever its fraction is.
- R3: With a period P > 0 held steady, the count falls by one on each clock from P-1 down to 0 and then restarts. Ready is therefore withheld for exactly min(F, P) consecutive cycles out of every P cycles.
- R4: A count that is zero, or that is at or above the current period (for example after the period has been lowered), is reloaded to period-1 on the next rising edge. The ready value set at that edge is judged on the reloaded count.
- R5: Ready is withheld on any edge where the updated count is below the fraction, and is asserted otherwise. A fraction at or above a nonzero period keeps ready withheld.
- R6: The outputs are registered on the rising edge. After reset is released with period P and fraction F, the first withheld cycle follows edge P-F+1.
- R7: `line_hold_n` is the active-low form of channel 0 ready: 1 means the peer must stop, 0 means it may send. `flag_ready` is active-high: 1 means the peer may send.
- R8: The two channels are independent. The settings of one channel do not change the pattern of the other.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| line_period | input | 16 | Handshake channel period in cycles, 0 = off |
| line_fraction | input | 16 | Handshake channel withheld cycles per period |
| flag_period | input | 16 | Flag channel period in cycles, 0 = off |
| flag_fraction | input | 16 | Flag channel withheld cycles per period |
| line_hold_n | output | 1 | Active-low handshake line, 1 = stop |
| flag_ready | output | 1 | Receive-allowed flag, 1 = may send |

## Verification
A reload and the fraction compare can happen in the same cycle. This occurs when the period is lowered below the running count: that edge must judge ready on the reloaded period-1 and not on the old count minus one. The bench provokes this case by running with period 8 and fraction 4. Two edges after reset the count is 6. The bench then lowers the period to 4 and requires ready to be withheld at the very next edge, because a plain decrement would give 5 and leave ready asserted. The bench also counts withheld cycles over a fixed window for several settings on both channels.

// File: rtl/thr_pkg.sv
// Package: thr_pkg
// Shared width and channel-count constants for the throttle generator.
// Assumes every channel uses the same count width.
package thr_pkg;
    localparam int THR_CNT_W = 16;
    localparam int THR_N_CH  = 2;
    localparam int THR_CH_LINE = 0;
    localparam int THR_CH_FLAG = 1;
endpackage

// File: rtl/thr_countdown.sv
// Module: thr_countdown
// Down-counter that wraps at a programmable period. An out-of-range count
// (zero, or at/above the period) reloads to period-1. With period zero the
// count holds. Also exposes the updated count for the ready comparison.
// Assumes the period may change on any cycle.
module thr_countdown #(
    parameter int W = thr_pkg::THR_CNT_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] period_i,
    output logic [W-1:0] cnt_q_o,
    output logic [W-1:0] cnt_next_o
);
    localparam logic [W-1:0] ONE = W'(1);

    logic [W-1:0] cnt_q;
    logic         in_range;
    logic         off;

    // Decide whether the count can step down or must reload.
    always_comb begin
        off      = (period_i == '0);
        in_range = (cnt_q != '0) && (cnt_q < period_i);
        if (off)
            cnt_next_o = cnt_q;
        else if (in_range)
            cnt_next_o = cnt_q - ONE;
        else
            cnt_next_o = period_i - ONE;
    end

    // Count register with synchronous active-low clear.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else
            cnt_q <= cnt_next_o;
    end

    assign cnt_q_o = cnt_q;

    AST_CNT_BELOW_PERIOD: assert property (@(posedge clk) disable iff (!rst_n)
        (period_i != '0) |=> (cnt_q < $past(period_i)));                   // R4
    AST_CNT_STEP_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
        (period_i != '0 && cnt_q != '0 && cnt_q < period_i)
        |=> (cnt_q == $past(cnt_q) - ONE));                                 // R3
    AST_CNT_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (period_i != '0 && (cnt_q == '0 || cnt_q >= period_i))
        |=> (cnt_q == $past(period_i) - ONE));                              // R4
endmodule

// File: rtl/thr_gate.sv
// Module: thr_gate
// Registers the ready level from the updated count and the fraction.
// Ready is withheld when the count is below the fraction. It is forced
// asserted while the channel is off (period zero) and during reset.
module thr_gate #(
    parameter int W = thr_pkg::THR_CNT_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         off_i,
    input  logic [W-1:0] cnt_next_i,
    input  logic [W-1:0] fraction_i,
    output logic         ready_o
);
    logic withhold;

    // Compare the updated count with the fraction.
    always_comb withhold = !off_i && (cnt_next_i < fraction_i);

    // Ready register, asserted out of reset.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ready_o <= 1'b1;
        else
            ready_o <= !withhold;
    end

    AST_OFF_READY: assert property (@(posedge clk) disable iff (!rst_n)
        off_i |=> ready_o);                                                 // R2
    AST_RESET_READY: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> ready_o);                                         // R1
endmodule

// File: rtl/thr_channel.sv
// Module: thr_channel
// One throttle channel: a countdown plus a ready gate.
// Assumes period and fraction are synchronous to clk.
module thr_channel #(
    parameter int W = thr_pkg::THR_CNT_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] period_i,
    input  logic [W-1:0] fraction_i,
    output logic         ready_o
);
    logic [W-1:0] cnt_q;
    logic [W-1:0] cnt_next;
    logic         off;

    // Channel off flag.
    always_comb off = (period_i == '0);

    thr_countdown #(.W(W)) u_cnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .period_i   (period_i),
        .cnt_q_o    (cnt_q),
        .cnt_next_o (cnt_next)
    );

    thr_gate #(.W(W)) u_gate (
        .clk        (clk),
        .rst_n      (rst_n),
        .off_i      (off),
        .cnt_next_i (cnt_next),
        .fraction_i (fraction_i),
        .ready_o    (ready_o)
    );

    AST_FULL_FRACTION: assert property (@(posedge clk) disable iff (!rst_n)
        (period_i != '0 && fraction_i >= period_i) |=> !ready_o);           // R5
    AST_WITHHOLD_LOW_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        (period_i != '0 && cnt_q != '0 && cnt_q < period_i && cnt_q <= fraction_i)
        |=> !ready_o);                                                      // R5
endmodule

// File: rtl/throttle_gen.sv
// Module: throttle_gen
// Two independent duty-cycle throttle channels. Channel 0 drives an
// active-low handshake line (1 = stop). Channel 1 drives an active-high
// receive-allowed flag. Settings may change at run time.
module throttle_gen #(
    parameter int W = thr_pkg::THR_CNT_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] line_period,
    input  logic [W-1:0] line_fraction,
    input  logic [W-1:0] flag_period,
    input  logic [W-1:0] flag_fraction,
    output logic         line_hold_n,
    output logic         flag_ready
);
    localparam int NCH = thr_pkg::THR_N_CH;

    logic [W-1:0] per   [NCH];
    logic [W-1:0] frac  [NCH];
    logic [NCH-1:0] rdy;

    // Route the per-channel settings into arrays.
    always_comb begin
        per[thr_pkg::THR_CH_LINE]  = line_period;
        frac[thr_pkg::THR_CH_LINE] = line_fraction;
        per[thr_pkg::THR_CH_FLAG]  = flag_period;
        frac[thr_pkg::THR_CH_FLAG] = flag_fraction;
    end

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        thr_channel #(.W(W)) u_ch (
            .clk        (clk),
            .rst_n      (rst_n),
            .period_i   (per[g]),
            .fraction_i (frac[g]),
            .ready_o    (rdy[g])
        );
    end

    // Output polarity per channel.
    always_comb begin
        line_hold_n = !rdy[thr_pkg::THR_CH_LINE];
        flag_ready  = rdy[thr_pkg::THR_CH_FLAG];
    end

    AST_LINE_OFF_GO: assert property (@(posedge clk) disable iff (!rst_n)
        (line_period == '0) |=> !line_hold_n);                              // R7
    AST_FLAG_OFF_GO: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_period == '0) |=> flag_ready);                                // R8
endmodule

// File: tb/throttle_gen_bench.sv
module throttle_gen_bench;
    localparam int W = 16;
    localparam int WIN = 240;
    localparam int NV = 6;
    // line period, line fraction, flag period, flag fraction, exp line, exp flag
    localparam int TLP [NV] = '{8, 0, 4, 1, 10, 3};
    localparam int TLF [NV] = '{3, 5, 4, 1, 7, 0};
    localparam int TFP [NV] = '{5, 1, 6, 12, 0, 2};
    localparam int TFF [NV] = '{2, 0, 9, 1, 0, 1};
    localparam int TEL [NV] = '{90, 0, 240, 240, 168, 0};
    localparam int TEF [NV] = '{96, 0, 240, 20, 0, 120};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [W-1:0] line_period = '0, line_fraction = '0;
    logic [W-1:0] flag_period = '0, flag_fraction = '0;
    logic line_hold_n, flag_ready;
    int checks = 0, errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    throttle_gen #(.W(W)) u_throttle_gen (
        .clk(clk), .rst_n(rst_n),
        .line_period(line_period), .line_fraction(line_fraction),
        .flag_period(flag_period), .flag_fraction(flag_fraction),
        .line_hold_n(line_hold_n), .flag_ready(flag_ready)
    );

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            @(negedge clk);
        end
    endtask

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    initial begin
        #1600000;
        errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int wl, wf, v;
        @(negedge clk);
        tick(3);
        // R1: reset state
        chk("R1 flag", flag_ready, 1);
        chk("R1 line", line_hold_n, 0);

        // Table walk: R3 R5 R7 R8 R2
        rst_n = 1'b1;
        for (int r = 0; r < NV; r++) begin
            line_period = W'(TLP[r]); line_fraction = W'(TLF[r]);
            flag_period = W'(TFP[r]); flag_fraction = W'(TFF[r]);
            tick(20);
            wl = 0; wf = 0;
            for (int c = 0; c < WIN; c++) begin
                tick(1);
                if (line_hold_n) wl++;
                if (!flag_ready) wf++;
            end
            chk("R3/R7 line withheld count", wl, TEL[r]);
            chk("R3/R8 flag withheld count", wf, TEF[r]);
        end

        // R6: phase after reset release, P=8 F=3 on both channels
        rst_n = 1'b0;
        line_period = 16'd8; line_fraction = 16'd3;
        flag_period = 16'd8; flag_fraction = 16'd3;
        tick(2);
        rst_n = 1'b1;
        for (int k = 1; k <= 16; k++) begin
            tick(1);
            v = 7 - ((k - 1) % 8);
            chk("R6 flag phase", flag_ready, (v < 3) ? 0 : 1);
        end

        // R4: lower period below running count; reload judged same edge
        rst_n = 1'b0;
        flag_period = 16'd8; flag_fraction = 16'd4;
        tick(2);
        rst_n = 1'b1;
        tick(2);
        chk("R4 before change", flag_ready, 1);
        flag_period = 16'd4;
        tick(1);
        chk("R4 reload withheld", flag_ready, 0);

        // R5: fraction at/above period keeps withheld
        flag_period = 16'd5; flag_fraction = 16'd5;
        tick(2);
        wf = 0;
        for (int c = 0; c < 15; c++) begin
            tick(1);
            if (!flag_ready) wf++;
        end
        chk("R5 full fraction", wf, 15);

        // R2: period zero with large fraction stays ready
        flag_period = 16'd0; flag_fraction = 16'd100;
        tick(1);
        chk("R2 zero period", flag_ready, 1);

        // R1: reset mid-run while withheld
        line_period = 16'd4; line_fraction = 16'd4;
        tick(3);
        chk("R5 line withheld", line_hold_n, 1);
        rst_n = 1'b0;
        tick(1);
        chk("R1 mid-run reset", line_hold_n, 0);
        rst_n = 1'b1;

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule